// File: doc/BRIEF.md
# Port Isolation Forwarding Filter

This block decides, for each frame, which egress ports of a small switch (up to nine ports) may carry it. Software fills two kinds of per-port state through plain write pins. The first is a five-bit control word per port: receive off, transmit off, and three receive gates used only by the management port. The second is a membership mask per ingress port, which lists the egress ports that the ingress port may reach. The management port is the highest-numbered port, port 8 by default.

A lookup carries an ingress port, a frame class and a candidate destination bitmap. It enters on a valid/ready request stream. The filtered bitmap leaves on a valid/ready result stream and is registered one cycle after the request is accepted. The result stage holds one entry. The rule for accepting a request is `req_ready = !res_valid || res_ready`, so a stalled result blocks new requests and nothing is dropped. While `res_valid` is high and `res_ready` is low, the result bitmap must stay unchanged. Putting each user port in isolation, with its mask holding only itself and the management port, stops all traffic between user ports.

Top module: `pisol_filter`

## Requirements
- R1: After reset every membership mask is all ones (0x1FF) and every control word is zero. A unicast lookup from port 0 with candidate 0x1FF therefore returns 0x0FE.
- R2: If the ingress port has receive-off set (control bit 0), the result is 0.
- R3: A port with transmit-off set (control bit 1) never appears in any result.
- R4: The result is a subset of the candidate AND the ingress port's membership mask. Only mask bits 8..0 count, and bits 15..9 of a written mask have no effect.
- R5: The ingress port's own bit is always cleared in the result.
- R6: The management-port bit survives only when its gate for the frame class is set in the management port's control word. Class 0 is unicast and uses bit 4. Class 1 is multicast and uses bit 3. Class 2 is broadcast and uses bit 2. Class 3 never reaches the management port.
- R7: Writing zero to a control word clears both disables, and the port forwards again.
- R8: When mask i is set to bit i plus bit 8 for each user port i, a lookup from any user port with candidate 0x1FF reaches only the management port, provided its unicast gate is open.
- R9: The result appears in the cycle after the request is accepted. `req_ready = !res_valid || res_ready`. Results come out in request order. A stalled result holds its value.
- R10: Control writes use `cfg_sel`=0 with the port number in `cfg_addr`. Mask writes use `cfg_sel`=1 with byte address 2×port. A mask write to an odd address, or any write to a port at or above 9, changes nothing. A lookup with an ingress port at or above 9 returns 0.
- R11: A lookup accepted in the same cycle as a configuration write uses the state from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = control word, 1 = membership mask |
| cfg_addr | input | 8 | Port number (control) or byte address 2×port (mask) |
| cfg_wdata | input | 16 | Write data; control uses bits 4..0 |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted this cycle if valid |
| req_port | input | 4 | Ingress port |
| req_class | input | 2 | Frame class: 0 unicast, 1 multicast, 2 broadcast, 3 reserved |
| req_cand | input | 9 | Candidate destination bitmap |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_ports | output | 9 | Filtered egress bitmap |

## Verification
The bench checks each management-port gate on its own against every frame class. A design that mixed up bits 2 to 4 would send broadcasts on the unicast gate, and the reserved class would leak through to the management port. It writes masks with the upper halfword bits set, writes to odd addresses, and uses ingress ports out of range. A decoder that used the full 16 bits, or that aliased addresses, would then widen the egress set or corrupt a neighbouring port's mask. Random back-pressure on the result stream exposes two faults: a stage that overwrites a stalled result, and one that lets results get out of order. A lookup issued in the same cycle as a write shows whether the result uses pre-write state or is reordered after the write.

// File: rtl/pisol_pkg.sv
package pisol_pkg;

  typedef enum logic [1:0] {
    CLS_UCAST = 2'd0,
    CLS_MCAST = 2'd1,
    CLS_BCAST = 2'd2,
    CLS_RSVD  = 2'd3
  } frame_class_e;

  // bit 0 rx_off, bit 1 tx_off, bit 2 bcast gate, bit 3 mcast gate, bit 4 ucast gate
  typedef struct packed {
    logic uc_en;
    logic mc_en;
    logic bc_en;
    logic tx_off;
    logic rx_off;
  } port_ctrl_t;

  localparam int CTRL_W = 5;

endpackage

// File: rtl/pisol_cfg_regs.sv
module pisol_cfg_regs
  import pisol_pkg::*;
#(
  parameter int NPORTS = 9,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_we,
  input  logic                            cfg_sel,
  input  logic [ADDR_W-1:0]               cfg_addr,
  input  logic [DATA_W-1:0]               cfg_wdata,
  output port_ctrl_t [NPORTS-1:0]         ctrl_q,
  output logic [NPORTS-1:0][NPORTS-1:0]   mask_q
);

  // One control word and one mask per port. Odd mask addresses and
  // out-of-range ports simply match no slot.
  for (genvar g = 0; g < NPORTS; g++) begin : g_port
    logic hit_ctrl;
    logic hit_mask;

    assign hit_ctrl = cfg_we && !cfg_sel && (cfg_addr == ADDR_W'(g));
    assign hit_mask = cfg_we &&  cfg_sel && (cfg_addr == ADDR_W'(2 * g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctrl_q[g] <= '0;
        mask_q[g] <= '1;
      end else begin
        if (hit_ctrl) ctrl_q[g] <= port_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
        if (hit_mask) mask_q[g] <= cfg_wdata[NPORTS-1:0];
      end
    end
  end

  // R10: a write that hits no port leaves all state untouched
  assert_cfg_stray_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel && cfg_addr[0]) |=> (mask_q == $past(mask_q)));

endmodule

// File: rtl/pisol_egress_calc.sv
module pisol_egress_calc
  import pisol_pkg::*;
#(
  parameter int NPORTS   = 9,
  parameter int CPU_PORT = NPORTS - 1,
  parameter int PORT_W   = $clog2(NPORTS)
) (
  input  port_ctrl_t [NPORTS-1:0]         ctrl_q,
  input  logic [NPORTS-1:0][NPORTS-1:0]   mask_q,
  input  logic [PORT_W-1:0]               in_port,
  input  frame_class_e                    in_class,
  input  logic [NPORTS-1:0]               in_cand,
  output logic [NPORTS-1:0]               out_ports
);

  logic              port_ok;
  logic [PORT_W-1:0] idx;
  logic [NPORTS-1:0] tx_open;
  logic [NPORTS-1:0] self_bit;
  logic              cpu_gate;
  port_ctrl_t        cpu_ctrl;

  assign port_ok  = (int'(in_port) < NPORTS);
  assign idx      = port_ok ? in_port : '0;
  assign cpu_ctrl = ctrl_q[CPU_PORT];

  for (genvar g = 0; g < NPORTS; g++) begin : g_tx
    assign tx_open[g]  = !ctrl_q[g].tx_off;
    assign self_bit[g] = (int'(idx) == g);
  end

  always_comb begin
    unique case (in_class)
      CLS_UCAST: cpu_gate = cpu_ctrl.uc_en;
      CLS_MCAST: cpu_gate = cpu_ctrl.mc_en;
      CLS_BCAST: cpu_gate = cpu_ctrl.bc_en;
      default:   cpu_gate = 1'b0;
    endcase
  end

  always_comb begin
    out_ports = in_cand & mask_q[idx] & tx_open & ~self_bit;
    if (!cpu_gate) out_ports[CPU_PORT] = 1'b0;
    if (!port_ok || ctrl_q[idx].rx_off) out_ports = '0;
  end

endmodule

// File: rtl/pisol_filter.sv
module pisol_filter
  import pisol_pkg::*;
#(
  parameter int NPORTS   = 9,
  parameter int CPU_PORT = NPORTS - 1,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int PORT_W   = $clog2(NPORTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [PORT_W-1:0] req_port,
  input  logic [1:0]        req_class,
  input  logic [NPORTS-1:0] req_cand,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [NPORTS-1:0] res_ports
);

  port_ctrl_t [NPORTS-1:0]       ctrl_q;
  logic [NPORTS-1:0][NPORTS-1:0] mask_q;
  logic [NPORTS-1:0]             calc_ports;
  logic                          fire;

  pisol_cfg_regs #(.NPORTS(NPORTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .ctrl_q(ctrl_q), .mask_q(mask_q)
  );

  pisol_egress_calc #(.NPORTS(NPORTS), .CPU_PORT(CPU_PORT), .PORT_W(PORT_W)) u_calc (
    .ctrl_q(ctrl_q), .mask_q(mask_q), .in_port(req_port),
    .in_class(frame_class_e'(req_class)), .in_cand(req_cand),
    .out_ports(calc_ports)
  );

  assign req_ready = !res_valid || res_ready;
  assign fire      = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_ports <= '0;
    end else if (fire) begin
      res_valid <= 1'b1;
      res_ports <= calc_ports;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  // Views of the stored state, used only by the checks below.
  logic [NPORTS-1:0] tx_off_vec;
  logic [NPORTS-1:0] sel_mask;
  logic              sel_rx_off;
  logic              port_in_range;
  for (genvar g = 0; g < NPORTS; g++) begin : g_view
    assign tx_off_vec[g] = ctrl_q[g].tx_off;
  end
  assign port_in_range = (int'(req_port) < NPORTS);
  assign sel_mask      = port_in_range ? mask_q[req_port] : '0;
  assign sel_rx_off    = port_in_range ? ctrl_q[req_port].rx_off : 1'b1;

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_ports)));

  assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> res_valid);

  assert_rx_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && sel_rx_off) |=> (res_ports == '0));

  assert_tx_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> ((res_ports & $past(tx_off_vec)) == '0));

  assert_in_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> ((res_ports & ~($past(sel_mask) & $past(req_cand))) == '0));

  assert_no_self_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && port_in_range) |=> (res_ports[$past(req_port)] == 1'b0));

  assert_rsvd_class_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_class == 2'd3) |=> !res_ports[CPU_PORT]);

endmodule

// File: tb/sim_pisol_filter.sv
module sim_pisol_filter;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic       cfg_sel = 1'b0;
  logic [7:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [3:0] req_port = '0;
  logic [1:0] req_class = '0;
  logic [8:0] req_cand = '0;
  logic       res_valid;
  logic       res_ready = 1'b1;
  logic [8:0] res_ports;

  always #10 clk = ~clk;  // 50 MHz

  pisol_filter u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_port(req_port), .req_class(req_class),
    .req_cand(req_cand), .res_valid(res_valid), .res_ready(res_ready),
    .res_ports(res_ports)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [4:0] m_ctrl [9];
  logic [8:0] m_mask [9];
  logic [8:0] exp_q [$];
  string      tag_q [$];

  bit bp_on = 0;
  int bp_cnt = 0;

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] model(input int p, input int c, input logic [8:0] cand);
    logic [8:0] r;
    logic [8:0] tx;
    logic gate;
    if (p >= 9) return '0;
    if (m_ctrl[p][0]) return '0;
    for (int k = 0; k < 9; k++) tx[k] = m_ctrl[k][1];
    r = cand & m_mask[p] & ~tx;
    r[p] = 1'b0;
    case (c)
      0: gate = m_ctrl[8][4];
      1: gate = m_ctrl[8][3];
      2: gate = m_ctrl[8][2];
      default: gate = 1'b0;
    endcase
    if (!gate) r[8] = 1'b0;
    return r;
  endfunction

  function automatic void model_write(input bit sel, input int addr, input logic [15:0] d);
    if (!sel) begin
      if (addr < 9) m_ctrl[addr] = d[4:0];
    end else begin
      if (addr % 2 == 0 && addr / 2 < 9) m_mask[addr / 2] = d[8:0];
    end
  endfunction

  // All tasks start and end just after a rising edge.
  task automatic cfg_write(input bit sel, input int addr, input logic [15:0] d);
    cfg_we = 1; cfg_sel = sel; cfg_addr = 8'(addr); cfg_wdata = d;
    model_write(sel, addr, d);
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic lookup(input int p, input int c, input logic [8:0] cand, input string tag);
    req_valid = 1; req_port = 4'(p); req_class = 2'(c); req_cand = cand;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    exp_q.push_back(model(p, c, cand));
    tag_q.push_back(tag);
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  // R11: write and lookup in the same cycle; expectation uses pre-write state
  task automatic lookup_with_write(input int p, input int c, input logic [8:0] cand,
                                   input bit sel, input int addr, input logic [15:0] d);
    req_valid = 1; req_port = 4'(p); req_class = 2'(c); req_cand = cand;
    cfg_we = 1; cfg_sel = sel; cfg_addr = 8'(addr); cfg_wdata = d;
    @(negedge clk);
    check(req_ready == 1'b1, "R11 ready for concurrent lookup", 16'(req_ready), 16'd1);
    exp_q.push_back(model(p, c, cand));
    tag_q.push_back("R11 lookup beside write");
    model_write(sel, addr, d);
    @(posedge clk); #1;
    req_valid = 0; cfg_we = 0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(posedge clk);
    #1;
  endtask

  // Monitor: pop and compare on each result handshake.
  always @(negedge clk) begin
    if (rst_n && res_valid && res_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 result with no request", 16'(res_ports), 16'h0);
      end else begin
        logic [8:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(res_ports == e, t, 16'(res_ports), 16'(e));
      end
    end
  end

  // Consumer back-pressure pattern.
  always @(posedge clk) begin
    #1;
    bp_cnt++;
    if (bp_on) res_ready = ((bp_cnt * 7) % 5) < 2;
    else       res_ready = 1'b1;
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 9; k++) begin m_ctrl[k] = '0; m_mask[k] = 9'h1FF; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(res_valid == 1'b0, "R1 res_valid low after reset", 16'(res_valid), 16'd0);
    check(req_ready == 1'b1, "R1 req_ready high after reset", 16'(req_ready), 16'd1);
    @(posedge clk); #1;

    // R1 reset state
    lookup(0, 0, 9'h1FF, "R1 reset lookup port0 ucast");
    @(negedge clk);
    check(res_valid == 1'b1, "R9 result one cycle after accept", 16'(res_valid), 16'd1);
    check(res_ports == 9'h0FE, "R1 reset value", 16'(res_ports), 16'h0FE);
    @(posedge clk); #1;
    lookup(3, 2, 9'h1FF, "R1 reset lookup port3 bcast");

    // R6 management-port gates, one at a time
    cfg_write(0, 8, 16'h0004);
    for (int c = 0; c < 4; c++) lookup(1, c, 9'h1FF, "R6 bcast gate only");
    cfg_write(0, 8, 16'h0008);
    for (int c = 0; c < 4; c++) lookup(1, c, 9'h1FF, "R6 mcast gate only");
    cfg_write(0, 8, 16'h0010);
    for (int c = 0; c < 4; c++) lookup(1, c, 9'h1FF, "R6 ucast gate only");
    cfg_write(0, 8, 16'h001C);
    for (int c = 0; c < 4; c++) lookup(1, c, 9'h1FF, "R6 all gates open");

    // R2 receive off, R3 transmit off
    cfg_write(0, 2, 16'h0001);
    lookup(2, 0, 9'h1FF, "R2 rx-off ingress empties result");
    lookup(0, 0, 9'h1FF, "R2 rx-off port still a destination");
    cfg_write(0, 4, 16'h0002);
    lookup(0, 1, 9'h1FF, "R3 tx-off port removed");
    lookup(7, 2, 9'h0F0, "R3 tx-off port removed, partial cand");

    // R7 zero restores forwarding
    cfg_write(0, 2, 16'h0000);
    cfg_write(0, 4, 16'h0000);
    lookup(2, 0, 9'h1FF, "R7 port2 forwards again");
    lookup(0, 0, 9'h1FF, "R7 port4 egress again");

    // R4 mask AND, upper bits ignored; R5 self removal
    cfg_write(1, 10, 16'hFE21);
    lookup(5, 0, 9'h1FF, "R4 upper mask bits ignored");
    lookup(5, 0, 9'h0E0, "R4 cand and mask disjoint except self");
    lookup(6, 0, 9'h040, "R5 self-only candidate gives 0");

    // R8 isolation
    for (int i = 0; i < 8; i++) cfg_write(1, 2 * i, 16'((1 << i) | 9'h100));
    for (int i = 0; i < 8; i++) lookup(i, 0, 9'h1FF, "R8 isolated port reaches only CPU");
    lookup(8, 0, 9'h1FF, "R8 CPU port reaches all users");

    // R10 stray writes and out-of-range ingress
    cfg_write(1, 3, 16'h0000);
    cfg_write(0, 9, 16'h0003);
    cfg_write(1, 18, 16'h0000);
    lookup(1, 0, 9'h1FF, "R10 odd mask address ignored");
    lookup(8, 2, 9'h1FF, "R10 out-of-range writes ignored");
    lookup(12, 0, 9'h1FF, "R10 out-of-range ingress gives 0");
    lookup(9, 1, 9'h1FF, "R10 ingress 9 gives 0");

    // R11 concurrent write and lookup
    lookup_with_write(3, 0, 9'h1FF, 0, 3, 16'h0001);
    lookup(3, 0, 9'h1FF, "R11 write visible afterwards");
    cfg_write(0, 3, 16'h0000);
    lookup_with_write(8, 0, 9'h1FF, 1, 16, 16'h0003);
    lookup(8, 0, 9'h1FF, "R11 mask write visible afterwards");
    drain();

    // R9 ordering and hold under back-pressure
    for (int i = 0; i < 9; i++) cfg_write(1, 2 * i, 16'h01FF);
    bp_on = 1;
    for (int i = 0; i < 24; i++)
      lookup(i % 9, i % 4, 9'((i * 37 + 5) & 9'h1FF), "R9 order under back-pressure");
    drain();
    bp_on = 0;
    @(posedge clk); #1;
    drain();

    finished = 1;
    summary();
    $finish;
  end

endmodule